// File: doc/BRIEF.md
# Supply Voltage Monitor with Undervoltage Interrupt

The block watches a digitized system-supply reading, given in millivolts with a valid strobe, and compares it with three limits. The lowest limit, about 1.4 V, gates register access. The middle limit, about 2.5 V, is the lockout level that decides whether the regulator outputs may run. The third limit is a warning level that software programs anywhere from 1.85 V to 3.35 V. Only the warning raises a flag for software: a sticky status bit and an active-low interrupt pin. Software can mask the interrupt. The warning never stops the outputs.

Each comparison has 50 mV of hysteresis, so a noisy reading near a limit cannot toggle the result. All three comparisons update only on a strobed sample. Every output comes straight from a flop, so none of them can glitch.

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted, reg_access_en and out_allowed are 0, warn_stat is 0 and irq_n is 1.
- R2: The comparison results change only at a clock edge where sample_vld is 1. At other edges reg_access_en, out_allowed and the warning condition hold their values.
- R3: reg_access_en goes to 1 on a valid sample of 1450 mV or more. It goes to 0 on a valid sample below 1400 mV. Samples from 1400 to 1449 mV leave it unchanged.
- R4: out_allowed goes to 1 on a valid sample of 2550 mV or more. It goes to 0 on a valid sample below 2500 mV. Samples from 2500 to 2549 mV leave it unchanged.
- R5: The warning threshold is 1850 mV + 100 mV × warn_code, where warn_code is an unsigned 4-bit value. A valid sample below the threshold starts the warning. A valid sample at or above threshold + 50 mV ends it. Samples in between leave it unchanged.
- R6: warn_stat is 1 at every edge where the warning is active. Once set, it stays 1 until stat_clr is 1 at an edge where the warning is no longer active. If stat_clr arrives in the same cycle as an active warning, the set wins.
- R7: At each edge, irq_n is loaded with the inverse of (new warn_stat AND NOT warn_mask). A change of warn_mask takes effect at the next edge.
- R8: The warning has no effect on out_allowed. A supply that is below the warning threshold but above the lockout level keeps out_allowed at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_mv | input | 12 | Supply reading in millivolts |
| sample_vld | input | 1 | sample_mv is valid this cycle |
| warn_code | input | 4 | Warning threshold select |
| warn_mask | input | 1 | 1 masks the interrupt |
| stat_clr | input | 1 | Clears the sticky warning status |
| reg_access_en | output | 1 | Supply above the reset-release level |
| out_allowed | output | 1 | Supply above the lockout level |
| warn_stat | output | 1 | Sticky undervoltage warning status |
| irq_n | output | 1 | Active-low warning interrupt |

## Verification
Two updates can land on the same edge: the status clear and a fresh sample that starts or keeps a warning. The directed sequence sends stat_clr together with a below-threshold sample and expects warn_stat to stay 1 and irq_n to stay low. It also sends stat_clr together with the sample that ends the warning and expects both to clear on that edge. The random phase toggles stat_clr, the mask and the threshold code on top of random samples. Each cycle's outputs are compared with a reference model in the bench.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int W            = 12,
  parameter int CW           = 4,
  parameter int POR_MV       = 1400,
  parameter int UVLO_MV      = 2500,
  parameter int WARN_BASE_MV = 1850,
  parameter int WARN_STEP_MV = 100,
  parameter int HYS_MV       = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  sample_mv,
  input  logic          sample_vld,
  input  logic [CW-1:0] warn_code,
  input  logic          warn_mask,
  input  logic          stat_clr,
  output logic          reg_access_en,
  output logic          out_allowed,
  output logic          warn_stat,
  output logic          irq_n
);
  localparam int TW = W + CW + 2;

  logic [TW-1:0] smp, warn_thr;
  logic por_q, uvlo_q, warn_q, stat_q, irq_q;
  logic por_n, uvlo_n, warn_n, stat_n;

  function automatic logic stays_high(input logic cur, input logic [TW-1:0] v,
                                      input logic [TW-1:0] lim);
    return cur ? (v >= lim) : (v >= lim + TW'(HYS_MV));
  endfunction

  assign smp      = TW'(sample_mv);
  assign warn_thr = TW'(WARN_BASE_MV) + TW'(warn_code) * TW'(WARN_STEP_MV);

  assign por_n  = sample_vld ? stays_high(por_q, smp, TW'(POR_MV)) : por_q;
  assign uvlo_n = sample_vld ? stays_high(uvlo_q, smp, TW'(UVLO_MV)) : uvlo_q;
  assign warn_n = sample_vld ? !stays_high(!warn_q, smp, warn_thr) : warn_q;
  assign stat_n = warn_n | (stat_q & ~stat_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q  <= 1'b0;
      uvlo_q <= 1'b0;
      warn_q <= 1'b0;
      stat_q <= 1'b0;
      irq_q  <= 1'b1;
    end else begin
      por_q  <= por_n;
      uvlo_q <= uvlo_n;
      warn_q <= warn_n;
      stat_q <= stat_n;
      irq_q  <= ~(stat_n & ~warn_mask);
    end
  end

  assign reg_access_en = por_q;
  assign out_allowed   = uvlo_q;
  assign warn_stat     = stat_q;
  assign irq_n         = irq_q;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int W            = 12,
  parameter int CW           = 4,
  parameter int POR_MV       = 1400,
  parameter int UVLO_MV      = 2500,
  parameter int WARN_BASE_MV = 1850,
  parameter int WARN_STEP_MV = 100,
  parameter int HYS_MV       = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  sample_mv,
  input logic          sample_vld,
  input logic [CW-1:0] warn_code,
  input logic          stat_clr,
  input logic          reg_access_en,
  input logic          out_allowed,
  input logic          warn_stat,
  input logic          irq_n
);
  int unsigned thr;
  assign thr = WARN_BASE_MV + int'(warn_code) * WARN_STEP_MV;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(reg_access_en) && $stable(out_allowed));

  assert_por_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && (int'(sample_mv) < POR_MV) |=> !reg_access_en);

  assert_uvlo_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && (int'(sample_mv) < UVLO_MV) |=> !out_allowed);

  assert_uvlo_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && (int'(sample_mv) >= UVLO_MV + HYS_MV) |=> out_allowed);

  assert_warn_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && (int'(sample_mv) < int'(thr)) |=> warn_stat);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warn_stat && !stat_clr |=> warn_stat);

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> warn_stat);
endmodule

bind supply_guard supply_guard_chk #(
  .W(W), .CW(CW), .POR_MV(POR_MV), .UVLO_MV(UVLO_MV),
  .WARN_BASE_MV(WARN_BASE_MV), .WARN_STEP_MV(WARN_STEP_MV), .HYS_MV(HYS_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_mv(sample_mv), .sample_vld(sample_vld),
  .warn_code(warn_code), .stat_clr(stat_clr), .reg_access_en(reg_access_en),
  .out_allowed(out_allowed), .warn_stat(warn_stat), .irq_n(irq_n)
);

// File: tb/sim_supply_guard.sv
`timescale 1ns/1ps
module sim_supply_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] sample_mv = '0;
  logic sample_vld = 1'b0;
  logic [3:0] warn_code = '0;
  logic warn_mask = 1'b0;
  logic stat_clr = 1'b0;
  logic reg_access_en, out_allowed, warn_stat, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_por, m_uvlo, m_warn, m_stat, m_irq;

  always #2.5 clk = ~clk;

  supply_guard u0 (
    .clk(clk), .rst_n(rst_n), .sample_mv(sample_mv), .sample_vld(sample_vld),
    .warn_code(warn_code), .warn_mask(warn_mask), .stat_clr(stat_clr),
    .reg_access_en(reg_access_en), .out_allowed(out_allowed),
    .warn_stat(warn_stat), .irq_n(irq_n)
  );

  function automatic bit hyst(input bit cur, input int v, input int lim);
    return cur ? (v >= lim) : (v >= lim + 50);
  endfunction

  task automatic expect_bit(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit vld, input int mv, input int code,
                     input bit mask, input bit clr);
    int thr;
    sample_vld = vld; sample_mv = 12'(mv); warn_code = 4'(code);
    warn_mask = mask; stat_clr = clr;
    thr = 1850 + code * 100;
    if (vld) begin
      m_por  = hyst(m_por, mv, 1400);
      m_uvlo = hyst(m_uvlo, mv, 2500);
      m_warn = !hyst(!m_warn, mv, thr);
    end
    m_stat = m_warn | (m_stat & !clr);
    m_irq  = !(m_stat & !mask);
    @(posedge clk); #1;
    expect_bit(reg_access_en, m_por, "R3 reg_access_en");
    expect_bit(out_allowed, m_uvlo, "R4 out_allowed");
    expect_bit(warn_stat, m_stat, "R6 warn_stat");
    expect_bit(irq_n, m_irq, "R7 irq_n");
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_por = 0; m_uvlo = 0; m_warn = 0; m_stat = 0; m_irq = 1;
    repeat (3) @(posedge clk);
    #1;
    expect_bit(reg_access_en, 1'b0, "R1 reg_access_en");
    expect_bit(out_allowed, 1'b0, "R1 out_allowed");
    expect_bit(warn_stat, 1'b0, "R1 warn_stat");
    expect_bit(irq_n, 1'b1, "R1 irq_n");
    rst_n = 1'b1;

    cyc(1, 1449, 0, 0, 0); expect_bit(reg_access_en, 0, "R3 below rise");
    cyc(1, 1450, 0, 0, 0); expect_bit(reg_access_en, 1, "R3 rise edge");
    cyc(1, 1400, 0, 0, 0); expect_bit(reg_access_en, 1, "R3 hysteresis hold");
    cyc(1, 1399, 0, 0, 0); expect_bit(reg_access_en, 0, "R3 drop");
    cyc(0, 3000, 0, 0, 0); expect_bit(reg_access_en, 0, "R2 no strobe");
    expect_bit(out_allowed, 0, "R2 no strobe");
    cyc(1, 2549, 0, 0, 0); expect_bit(out_allowed, 0, "R4 below rise");
    cyc(1, 2550, 0, 0, 0); expect_bit(out_allowed, 1, "R4 rise edge");
    cyc(1, 2500, 0, 0, 0); expect_bit(out_allowed, 1, "R4 hysteresis hold");
    cyc(1, 2499, 0, 0, 0); expect_bit(out_allowed, 0, "R4 drop");

    cyc(1, 3500, 0, 0, 1); expect_bit(warn_stat, 0, "R6 cleared");
    cyc(1, 1849, 0, 0, 0); expect_bit(warn_stat, 1, "R5 code 0 set");
    expect_bit(irq_n, 0, "R7 unmasked");
    cyc(1, 1899, 0, 0, 1); expect_bit(warn_stat, 1, "R6 clear while active");
    cyc(1, 1900, 0, 0, 0); expect_bit(warn_stat, 1, "R6 sticky after end");
    cyc(0, 1900, 0, 0, 1); expect_bit(warn_stat, 0, "R6 clear after end");
    expect_bit(irq_n, 1, "R7 released");

    cyc(1, 3500, 15, 0, 1);
    cyc(1, 3000, 15, 0, 0); expect_bit(warn_stat, 1, "R5 code 15 set");
    expect_bit(out_allowed, 1, "R8 outputs keep running");
    cyc(1, 3399, 15, 0, 1); expect_bit(warn_stat, 1, "R5 code 15 hold");
    cyc(1, 3400, 15, 0, 1); expect_bit(warn_stat, 0, "R5 code 15 end with clear");

    cyc(1, 2000, 5, 1, 0); expect_bit(warn_stat, 1, "R7 masked status");
    expect_bit(irq_n, 1, "R7 masked pin");
    cyc(0, 2000, 5, 0, 0); expect_bit(irq_n, 0, "R7 unmask");
    cyc(1, 2000, 5, 0, 1); expect_bit(warn_stat, 1, "R6 set beats clear");
    expect_bit(irq_n, 0, "R6 collision pin");

    for (int i = 0; i < 3000; i++) begin
      int code;
      code = int'($urandom_range(15));
      cyc(($urandom_range(9) < 7), 1000 + int'($urandom_range(2800)), code,
          ($urandom_range(4) == 0), ($urandom_range(9) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule